// File: doc/BRIEF.md
# Block-Stream Data-Available Flag Controller

This block sits behind the block decoder of a broadcast radio data stream. It does not look at the bits of a block. For each block that decodes cleanly it receives a strobe and the block's type. From those it tracks whether the decoder has locked onto the block sequence. It also keeps a data-available flag that tells the host when a fresh block is waiting in the data registers.

The flag follows a host-selected reporting mode. Mode A reports every block once locked. Mode B does the same, and while still searching it also reports a single clean A or C' block, so the station identifier can be picked up quickly during tuning. Mode C reports once per two blocks once locked.

When an external flywheel counter reports that lock was lost, a mask bit picks what happens next. With the mask clear, the search restarts on its own. With the mask set, the block raises a sync-lost flag and stays idle until the host asks for a new search. Reading either of two data-register addresses clears the data-available flag.

Top module: `stream_flag_ctrl`

## Requirements
- R1: After synchronous active-low reset the block is searching and avail_flag, synced, lost_flag and irq are all 0.
- R2: Block types are coded A=0, B=1, C=2, C'=3, D=4, and the cyclic order is A, B, C-or-C', D, A. While searching, a valid block that directly follows the previous valid block in that order, with bad_cnt < bad_lim, makes synced 1 and sets avail_flag at the same clock edge.
- R3: While searching, an in-order pair whose second block arrives with bad_cnt >= bad_lim does not lock. That block becomes the reference for the next order check.
- R4: The mode is coded 0=A, 1=B, 2 or 3=C. In mode B during search, a valid A or C' block sets avail_flag on its own. In modes A and C a lone block during search leaves the flag unchanged.
- R5: While synced in mode A or B, every valid block sets avail_flag.
- R6: While synced in mode C, avail_flag is set on every second valid block. The pair count is zeroed when lock is acquired, so the first block after lock does not set the flag.
- R7: A sync loss with lsync_mask = 0 sets avail_flag, drops synced and resumes the search with no reference block.
- R8: A sync loss with lsync_mask = 1 sets lost_flag, pulses irq and parks the block idle, with synced 0. Blocks received while idle change no output.
- R9: new_search while idle clears lost_flag and returns to the search at the next edge. new_search in other states has no effect.
- R10: A read strobe at address 15 or 17 clears avail_flag. A read at any other address leaves it. A set in the same cycle wins over the clear.
- R11: irq is a one-cycle pulse in the cycle after avail_flag is set while avail_irq_en is 1, or after an R8 sync loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_vld | input | 1 | One valid decoded block this cycle |
| blk_type | input | 3 | Type of that block (A=0, B=1, C=2, C'=3, D=4) |
| bad_cnt | input | BAD_W | Current bad-block count |
| bad_lim | input | BAD_W | Bad-block limit for acquiring lock |
| fly_loss | input | 1 | Flywheel sync-loss strobe |
| new_search | input | 1 | Host command to restart the search from idle |
| lsync_mask | input | 1 | 1: park idle on sync loss; 0: restart automatically |
| avail_irq_en | input | 1 | Interrupt enable for data-available events |
| mode | input | 2 | Reporting mode (0=A, 1=B, 2/3=C) |
| rd_en | input | 1 | Host register read strobe |
| rd_addr | input | ADDR_W | Address of that read |
| avail_flag | output | 1 | Data-available flag |
| synced | output | 1 | 1 while locked to the block sequence |
| lost_flag | output | 1 | Sync lost while the mask was set |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench goes after these corner cases:
- A set and a clearing read in the same cycle. A design that let the clear win would lose a block report.
- The first block after lock in mode C. A design that kept a stale pair count would report one block early.
- In-order pairs arriving with the bad count at exactly the limit. A design using a less-or-equal test would lock too soon.
- Blocks arriving while idle. A design that kept decoding there would lock without a host command.

Random mixes of modes, losses, mask values and reads are checked each cycle against a bench model built from the requirements.

// File: rtl/stream_flag_pkg.sv
// Shared types and block coding for the data-available flag controller.
package stream_flag_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_SYNC   = 2'd1,
        ST_IDLE   = 2'd2
    } sync_st_t;

    localparam logic [2:0] BT_A  = 3'd0;
    localparam logic [2:0] BT_B  = 3'd1;
    localparam logic [2:0] BT_C  = 3'd2;
    localparam logic [2:0] BT_CP = 3'd3;
    localparam logic [2:0] BT_D  = 3'd4;

    // Position of a block type in the cyclic order; C and C' share slot 2.
    function automatic logic [1:0] slot_of(input logic [2:0] t);
        case (t)
            BT_A:         slot_of = 2'd0;
            BT_B:         slot_of = 2'd1;
            BT_C, BT_CP:  slot_of = 2'd2;
            default:      slot_of = 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/sfc_order_chk.sv
// Order checker for the search phase.
// Remembers the slot of the last valid block seen while searching and flags
// when the current block is its direct successor with the bad count under the
// limit. Assumes blk_vld is only raised for known types (0..4). The reference
// is dropped whenever the controller is not searching.
module sfc_order_chk
    import stream_flag_pkg::*;
#(
    parameter int BAD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             searching,
    input  logic             blk_vld,
    input  logic [2:0]       blk_type,
    input  logic [BAD_W-1:0] bad_cnt,
    input  logic [BAD_W-1:0] bad_lim,
    output logic             seq_ok,
    output logic             early_id
);
    logic       ref_vld;
    logic [1:0] ref_slot;
    logic [1:0] cur_slot;

    // Decode the slot and test the succession rule.
    always_comb begin
        cur_slot = slot_of(blk_type);
        seq_ok   = searching && blk_vld && ref_vld &&
                   (cur_slot == ref_slot + 2'd1) && (bad_cnt < bad_lim);
        early_id = searching && blk_vld &&
                   ((blk_type == BT_A) || (blk_type == BT_CP));
    end

    // Keep the reference block; cleared outside the search state.
    always_ff @(posedge clk) begin
        if (!rst_n || !searching) begin
            ref_vld  <= 1'b0;
            ref_slot <= 2'd0;
        end else if (blk_vld) begin
            ref_vld  <= 1'b1;
            ref_slot <= cur_slot;
        end
    end

    // R3
    ref_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (searching && blk_vld && !seq_ok) |=> (ref_vld || !searching));
endmodule

// File: rtl/sfc_sync_fsm.sv
// Synchronization state machine.
// Moves between search, synchronized and idle, counts block pairs for mode C,
// keeps the sync-lost flag and issues one-cycle set and loss events to the
// flag stage. A sync loss takes priority over a block in the same cycle.
module sfc_sync_fsm
    import stream_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_vld,
    input  logic       seq_ok,
    input  logic       early_id,
    input  logic       fly_loss,
    input  logic       new_search,
    input  logic       lsync_mask,
    input  logic [1:0] mode,
    output sync_st_t   state,
    output logic       lost_flag,
    output logic       set_req,
    output logic       lose_evt
);
    logic     pair_q;
    logic     pair_d;
    logic     lost_d;
    sync_st_t state_d;
    logic     mode_c;

    // Next-state, pair count and event decode.
    always_comb begin
        mode_c   = mode[1];
        state_d  = state;
        pair_d   = pair_q;
        lost_d   = lost_flag;
        set_req  = 1'b0;
        lose_evt = 1'b0;
        case (state)
            ST_SEARCH: begin
                if (mode == 2'd1 && early_id) set_req = 1'b1;
                if (seq_ok) begin
                    state_d = ST_SYNC;
                    set_req = 1'b1;
                    pair_d  = 1'b0;
                end
            end
            ST_SYNC: begin
                if (fly_loss) begin
                    if (lsync_mask) begin
                        state_d  = ST_IDLE;
                        lost_d   = 1'b1;
                        lose_evt = 1'b1;
                    end else begin
                        state_d = ST_SEARCH;
                        set_req = 1'b1;
                    end
                end else if (blk_vld) begin
                    if (!mode_c) begin
                        set_req = 1'b1;
                    end else begin
                        set_req = pair_q;
                        pair_d  = ~pair_q;
                    end
                end
            end
            default: begin
                if (new_search) begin
                    state_d = ST_SEARCH;
                    lost_d  = 1'b0;
                end
            end
        endcase
    end

    // State, pair and lost-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_SEARCH;
            pair_q    <= 1'b0;
            lost_flag <= 1'b0;
        end else begin
            state     <= state_d;
            pair_q    <= pair_d;
            lost_flag <= lost_d;
        end
    end

    // R6
    pair_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && mode[1] && blk_vld && !fly_loss && !pair_q) |=> pair_q);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !new_search) |=> (state == ST_IDLE && lost_flag));
    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && new_search) |=> (state == ST_SEARCH && !lost_flag));
endmodule

// File: rtl/sfc_avail_flag.sv
// Data-available flag and interrupt stage.
// Holds the flag, clears it on a read of any address in the parameter list
// (a set in the same cycle wins) and forms a one-cycle interrupt pulse.
module sfc_avail_flag #(
    parameter int                        ADDR_W = 5,
    parameter int                        N_ADDR = 2,
    parameter logic [N_ADDR*ADDR_W-1:0]  CLR_ADDRS = {5'd17, 5'd15}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_req,
    input  logic              lose_evt,
    input  logic              avail_irq_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              avail_flag,
    output logic              irq
);
    logic [N_ADDR-1:0] hit;
    logic              clr;

    // One comparator per clearing address.
    for (genvar g = 0; g < N_ADDR; g++) begin : g_match
        assign hit[g] = (rd_addr == CLR_ADDRS[g*ADDR_W +: ADDR_W]);
    end

    assign clr = rd_en && (|hit);

    // Flag and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail_flag <= 1'b0;
            irq        <= 1'b0;
        end else begin
            if (set_req)  avail_flag <= 1'b1;
            else if (clr) avail_flag <= 1'b0;
            irq <= (set_req && avail_irq_en) || lose_evt;
        end
    end

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_req) |=> !avail_flag);
    // R11
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && avail_irq_en) |=> (irq && avail_flag));
endmodule

// File: rtl/stream_flag_ctrl.sv
// Top of the data-available flag controller.
// Connects the search order checker, the sync state machine and the flag
// stage. Assumes blk_vld is raised only for types 0..4.
module stream_flag_ctrl
    import stream_flag_pkg::*;
#(
    parameter int BAD_W  = 4,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_vld,
    input  logic [2:0]        blk_type,
    input  logic [BAD_W-1:0]  bad_cnt,
    input  logic [BAD_W-1:0]  bad_lim,
    input  logic              fly_loss,
    input  logic              new_search,
    input  logic              lsync_mask,
    input  logic              avail_irq_en,
    input  logic [1:0]        mode,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              avail_flag,
    output logic              synced,
    output logic              lost_flag,
    output logic              irq
);
    localparam int N_ADDR = 2;
    localparam logic [N_ADDR*ADDR_W-1:0] CLR_ADDRS =
        {ADDR_W'(17), ADDR_W'(15)};

    sync_st_t state;
    logic     seq_ok, early_id, set_req, lose_evt;

    sfc_order_chk #(.BAD_W(BAD_W)) u_order (
        .clk(clk), .rst_n(rst_n), .searching(state == ST_SEARCH),
        .blk_vld(blk_vld), .blk_type(blk_type), .bad_cnt(bad_cnt),
        .bad_lim(bad_lim), .seq_ok(seq_ok), .early_id(early_id)
    );

    sfc_sync_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .blk_vld(blk_vld), .seq_ok(seq_ok),
        .early_id(early_id), .fly_loss(fly_loss), .new_search(new_search),
        .lsync_mask(lsync_mask), .mode(mode), .state(state),
        .lost_flag(lost_flag), .set_req(set_req), .lose_evt(lose_evt)
    );

    sfc_avail_flag #(.ADDR_W(ADDR_W), .N_ADDR(N_ADDR), .CLR_ADDRS(CLR_ADDRS)) u_flag (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .lose_evt(lose_evt),
        .avail_irq_en(avail_irq_en), .rd_en(rd_en), .rd_addr(rd_addr),
        .avail_flag(avail_flag), .irq(irq)
    );

    assign synced = (state == ST_SYNC);

    // R8
    lost_not_synced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost_flag |-> !synced);
    // R2
    lock_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && seq_ok) |=> (synced && avail_flag));
endmodule

// File: tb/test_stream_flag_ctrl.sv
module test_stream_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_vld = 1'b0;
    logic [2:0] blk_type = 3'd0;
    logic [3:0] bad_cnt = 4'd0;
    logic [3:0] bad_lim = 4'd4;
    logic       fly_loss = 1'b0, new_search = 1'b0, lsync_mask = 1'b0;
    logic       avail_irq_en = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       rd_en = 1'b0;
    logic [4:0] rd_addr = 5'd0;
    logic       avail_flag, synced, lost_flag, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Bench model state: 0 search, 1 synced, 2 idle.
    int  m_st = 0;
    bit  m_pv = 0, m_pair = 0, m_av = 0, m_lost = 0, m_irq = 0;
    int  m_ps = 0;

    stream_flag_ctrl i_stream_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .blk_vld(blk_vld), .blk_type(blk_type),
        .bad_cnt(bad_cnt), .bad_lim(bad_lim), .fly_loss(fly_loss),
        .new_search(new_search), .lsync_mask(lsync_mask),
        .avail_irq_en(avail_irq_en), .mode(mode), .rd_en(rd_en),
        .rd_addr(rd_addr), .avail_flag(avail_flag), .synced(synced),
        .lost_flag(lost_flag), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic int slot(input logic [2:0] t);
        if (t == 3'd0) return 0;
        if (t == 3'd1) return 1;
        if (t == 3'd2 || t == 3'd3) return 2;
        return 3;
    endfunction

    task automatic chk(input string rq, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", rq, act, exp, $time);
        end
    endtask

    // Advance the model by one edge with the inputs currently driven.
    task automatic model_step();
        bit set = 0, lose = 0;
        bit clr = rd_en && (rd_addr == 5'd15 || rd_addr == 5'd17);
        if (m_st == 0) begin
            if (blk_vld) begin
                if (mode == 2'd1 && (blk_type == 3'd0 || blk_type == 3'd3)) set = 1;
                if (m_pv && slot(blk_type) == (m_ps + 1) % 4 && bad_cnt < bad_lim) begin
                    m_st = 1; set = 1; m_pair = 0; m_pv = 0;
                end else begin
                    m_pv = 1; m_ps = slot(blk_type);
                end
            end
        end else if (m_st == 1) begin
            if (fly_loss) begin
                if (lsync_mask) begin m_st = 2; m_lost = 1; lose = 1; end
                else begin m_st = 0; set = 1; end
                m_pv = 0;
            end else if (blk_vld) begin
                if (mode < 2) set = 1;
                else begin set = m_pair; m_pair = !m_pair; end
            end
        end else if (new_search) begin
            m_st = 0; m_lost = 0; m_pv = 0;
        end
        if (set) m_av = 1; else if (clr) m_av = 0;
        m_irq = (set && avail_irq_en) || lose;
    endtask

    // One clock: model update, then compare every output away from the edge.
    task automatic cyc();
        model_step();
        @(posedge clk); #2;
        chk("R2/R4/R5/R6/R7/R10 avail_flag", avail_flag, m_av);
        chk("R2/R7/R8 synced", synced, m_st == 1);
        chk("R8/R9 lost_flag", lost_flag, m_lost);
        chk("R11 irq", irq, m_irq);
        blk_vld = 0; fly_loss = 0; new_search = 0; rd_en = 0;
    endtask

    task automatic blk(input logic [2:0] t, input logic [3:0] b);
        blk_vld = 1; blk_type = t; bad_cnt = b; cyc();
    endtask

    task automatic rd(input logic [4:0] a);
        rd_en = 1; rd_addr = a; cyc();
    endtask

    initial begin
        #100000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(7));
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1 avail_flag", avail_flag, 0); chk("R1 synced", synced, 0);
        chk("R1 lost_flag", lost_flag, 0);   chk("R1 irq", irq, 0);
        rst_n = 1;
        lsync_mask = 1; mode = 0;
        blk(0, 0); blk(1, 0);
        chk("R2 lock", synced, 1); chk("R2 flag", avail_flag, 1); chk("R11 irq", irq, 1);
        rd(15); chk("R10 clear 15", avail_flag, 0);
        blk(2, 0); chk("R5 every block", avail_flag, 1);
        rd(3);  chk("R10 other addr", avail_flag, 1);
        rd(17); chk("R10 clear 17", avail_flag, 0);
        mode = 2;
        blk(4, 0); chk("R6 first of pair", avail_flag, 0);
        blk(0, 0); chk("R6 second of pair", avail_flag, 1);
        rd(15);
        fly_loss = 1; cyc();
        chk("R8 lost", lost_flag, 1); chk("R8 irq", irq, 1); chk("R8 unsynced", synced, 0);
        blk(0, 0); blk(1, 0);
        chk("R8 idle ignores blocks", synced, 0); chk("R8 idle flag", avail_flag, 0);
        new_search = 1; cyc(); chk("R9 lost cleared", lost_flag, 0);
        blk(0, 4); blk(1, 4); chk("R3 limit blocks lock", synced, 0);
        blk(2, 0); chk("R3 relock from B", synced, 1);
        rd(15);
        blk(4, 0); chk("R6 pair zeroed on lock", avail_flag, 0);
        blk(0, 0); chk("R6 pair second", avail_flag, 1);
        lsync_mask = 0; rd(15);
        fly_loss = 1; cyc();
        chk("R7 flag", avail_flag, 1); chk("R7 unsynced", synced, 0);
        rd(17); mode = 1;
        blk(3, 0); chk("R4 early C'", avail_flag, 1); chk("R4 no lock", synced, 0);
        rd(15); mode = 0;
        blk(0, 0); chk("R4 mode A no early", avail_flag, 0);
        // Set and clear together: set wins (R10).
        blk_vld = 1; blk_type = 1; bad_cnt = 0; rd_en = 1; rd_addr = 15; cyc();
        chk("R10 set wins", avail_flag, 1);
        // Constrained random phase.
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) mode = 2'($urandom_range(0, 3));
            if (r > 96) lsync_mask = 1'($urandom_range(0, 1));
            if (r == 50) avail_irq_en = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1) begin
                blk_vld = 1;
                if ($urandom_range(0, 3) != 0)
                    blk_type = (slot(blk_type) == 3) ? 3'd0 :
                               (slot(blk_type) == 2) ? 3'd4 :
                               (slot(blk_type) == 1) ? 3'($urandom_range(2, 3)) : 3'd1;
                else
                    blk_type = 3'($urandom_range(0, 4));
                bad_cnt = 4'($urandom_range(0, 6));
            end
            fly_loss   = ($urandom_range(0, 39) == 0);
            new_search = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 3) == 0) begin
                rd_en = 1;
                rd_addr = ($urandom_range(0, 2) == 0) ? 5'd15 :
                          ($urandom_range(0, 1) == 0) ? 5'd17 : 5'($urandom_range(0, 31));
            end
            cyc();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule